// File: doc/BRIEF.md
# Seeded Pseudo-Random Word Generator with Register Interface

A 32-bit register-mapped peripheral that produces a block of five pseudo-random words from a 160-bit seed. Software works in polling mode. It loads five seed words and writes the control register with the engine-select bit and the go bit both set. It then polls the status register until the generation-complete flag appears, and reads the five result words. There are no interrupts and no DMA.

A generation is refused unless every seed word has been written since reset and the engine is selected in the same control write. The go bit never stays set. While a generation runs, the busy flag is high and the result registers keep their old contents. At completion all five result registers are replaced in the same cycle. The engine is a 160-bit xorshift generator that advances one step per clock.

Top module: `seeded_rng_ctrl`

## Requirements
- R1: After reset the control register reads 0x00000000, the status register reads 0x00000001 and all five result registers (byte offsets 0x160, 0x164, 0x168, 0x16C, 0x170) read 0.
- R2: The control register sits at offset 0x00. Bit 3 selects the engine and bit 4 requests a start. A write stores the written word with bit 4 forced to 0, so bit 4 always reads back as 0.
- R3: The status register sits at offset 0x10. Its bits are: bit 0 ready (always 1), bit 1 all-seeds-loaded, bit 2 busy, bits 3 and 4 plain software flags, bit 5 generation complete, bit 7 error (always 0), and all other bits 0. A write to it replaces bits 5:3 with the written bits and leaves every other bit unchanged.
- R4: A write to offset 0x140 + 4·n (n = 0..4) stores seed word n and marks it loaded. Status bit 1 is 1 only when all five words are marked. The marks stay set until reset.
- R5: A control write launches a generation only if status bit 1 is set and the written word has both bit 3 and bit 4 set. Any other control write leaves busy low, leaves bit 5 unchanged and leaves the result registers unchanged.
- R6: Reads return data one cycle after the read strobe. A launch on a write edge makes busy read as 1 from the next cycle through 5·STEPS cycles. The following read shows busy 0 and bit 5 set, and all five result words are updated in that same cycle.
- R7: The 160-bit state is loaded with seed word n in bits [32n+31:32n]. One step is x ^= x<<7; x ^= x>>9; x ^= x<<13, all on 160 bits. Result word k (offset 0x160 + 4·k) is bits [31:0] of the state after STEPS·(k+1) steps.
- R8: If all five seed words are zero, the state is loaded with 0x9E3779B9 repeated five times instead.
- R9: A launching control write that arrives while busy is ignored. Seed writes made during a run are stored but do not affect that run's results.
- R10: Reads of any other offset in the 0x200-byte window return 0, including the seed offsets and unaligned addresses. Writes to such offsets change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 9 | Byte address within the register window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after rd_en, held otherwise |

## Verification
The assertions assume that the bus never raises wr_en and rd_en in the same cycle, and that every strobe lasts exactly one cycle with a stable address. They also assume that reset is held for at least one edge before any access. The bench drives every access from a task that raises one strobe at a falling edge and drops it at the next falling edge, so the bus is never overlapped. It starts the first access only after reset is released. Seed and control writes made during a run are deliberate: they exercise the case where a request arrives while busy, and are still single-strobe accesses.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int WORD_W = 32;

  // register byte offsets
  localparam int OFS_CTRL = 'h000;
  localparam int OFS_STAT = 'h010;
  localparam int OFS_SEED = 'h140;
  localparam int OFS_RES  = 'h160;

  // control bits
  localparam int CTL_ENG = 3;
  localparam int CTL_GO  = 4;

  // status bits
  localparam int ST_READY = 0;
  localparam int ST_SEEDS = 1;
  localparam int ST_BUSY  = 2;
  localparam int ST_SWLO  = 3;
  localparam int ST_DONE  = 5;
  localparam int ST_ERR   = 7;

  // xorshift shift amounts
  localparam int SH_A = 7;
  localparam int SH_B = 9;
  localparam int SH_C = 13;

  localparam logic [WORD_W-1:0] ZERO_FILL = 32'h9E37_79B9;
endpackage

// File: rtl/rng_seed_track.sv
module rng_seed_track #(
  parameter int NUM_SEEDS = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        seed_we,
  input  logic [IW-1:0]               seed_idx,
  input  logic [rng_pkg::WORD_W-1:0]  seed_val,
  output logic [NUM_SEEDS*rng_pkg::WORD_W-1:0] seed_flat,
  output logic                        seeds_all
);
  localparam int IW = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1;
  localparam int W  = rng_pkg::WORD_W;

  logic [NUM_SEEDS-1:0] loaded_q;

  for (genvar n = 0; n < NUM_SEEDS; n++) begin : g_seed
    logic [W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q      <= '0;
        loaded_q[n] <= 1'b0;
      end else if (seed_we && seed_idx == IW'(n)) begin
        word_q      <= seed_val;
        loaded_q[n] <= 1'b1;
      end
    end
    assign seed_flat[n*W +: W] = word_q;
  end

  assign seeds_all = &loaded_q;

  // R4
  seeds_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seeds_all |=> seeds_all);
endmodule

// File: rtl/rng_engine.sv
module rng_engine #(
  parameter int NUM_SEEDS = 5,
  parameter int STEPS     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_req,
  input  logic [SW_TOT-1:0]    seed_flat,
  output logic                 busy,
  output logic                 done,
  output logic [SW_TOT-1:0]    out_flat
);
  localparam int W      = rng_pkg::WORD_W;
  localparam int SW_TOT = NUM_SEEDS * W;
  localparam int CW     = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int KW     = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1;
  localparam logic [SW_TOT-1:0] ZERO_SUB = {NUM_SEEDS{rng_pkg::ZERO_FILL}};

  function automatic logic [SW_TOT-1:0] xs_step(input logic [SW_TOT-1:0] s);
    logic [SW_TOT-1:0] t;
    t = s ^ (s << rng_pkg::SH_A);
    t = t ^ (t >> rng_pkg::SH_B);
    t = t ^ (t << rng_pkg::SH_C);
    return t;
  endfunction

  logic [SW_TOT-1:0] state_q, state_nx, load_val;
  logic [CW-1:0]     step_q;
  logic [KW-1:0]     word_q;
  logic              busy_q;
  logic              last_step, last_word, launch;

  assign state_nx  = xs_step(state_q);
  assign load_val  = (seed_flat == '0) ? ZERO_SUB : seed_flat;
  assign last_step = (step_q == CW'(STEPS - 1));
  assign last_word = (word_q == KW'(NUM_SEEDS - 1));
  assign launch    = start_req && !busy_q;
  assign done      = busy_q && last_step && last_word;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      step_q  <= '0;
      word_q  <= '0;
      busy_q  <= 1'b0;
    end else if (launch) begin
      state_q <= load_val;
      step_q  <= '0;
      word_q  <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      state_q <= state_nx;
      if (last_step) begin
        step_q <= '0;
        if (last_word) begin
          busy_q <= 1'b0;
          word_q <= '0;
        end else begin
          word_q <= word_q + 1'b1;
        end
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NUM_SEEDS; k++) begin : g_word
    logic [W-1:0] hold_q, res_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q <= '0;
      end else if (busy_q && last_step && word_q == KW'(k)) begin
        hold_q <= state_nx[W-1:0];
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q <= '0;
      end else if (done) begin
        res_q <= (k == NUM_SEEDS - 1) ? state_nx[W-1:0] : hold_q;
      end
    end
    assign out_flat[k*W +: W] = res_q;
  end

  // R6
  done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_q);
  // R6
  results_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> $stable(out_flat));
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && busy_q && !last_step) |=> (step_q == $past(step_q) + 1'b1));
endmodule

// File: rtl/seeded_rng_ctrl.sv
module seeded_rng_ctrl #(
  parameter int ADDR_W    = 9,
  parameter int NUM_SEEDS = 5,
  parameter int STEPS     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data
);
  import rng_pkg::*;
  localparam int W      = WORD_W;
  localparam int IW     = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1;
  localparam int SW_TOT = NUM_SEEDS * W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(OFS_SEED);
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(OFS_RES);
  localparam logic [ADDR_W-1:0] A_SPAN = ADDR_W'(4 * NUM_SEEDS);

  // decode
  logic aligned, in_seed, in_res;
  logic wr_ctrl, wr_stat, wr_seed;
  logic [IW-1:0] seed_idx, res_idx;
  logic [ADDR_W-1:0] seed_rel, res_rel;

  assign aligned  = (addr[1:0] == 2'b00);
  assign seed_rel = addr - A_SEED;
  assign res_rel  = addr - A_RES;
  assign in_seed  = aligned && addr >= A_SEED && addr < A_SEED + A_SPAN;
  assign in_res   = aligned && addr >= A_RES  && addr < A_RES  + A_SPAN;
  assign seed_idx = IW'(seed_rel >> 2);
  assign res_idx  = IW'(res_rel >> 2);
  assign wr_ctrl  = wr_en && addr == A_CTRL;
  assign wr_stat  = wr_en && addr == A_STAT;
  assign wr_seed  = wr_en && in_seed;

  // seeds
  logic [SW_TOT-1:0] seed_flat, res_flat;
  logic seeds_all;

  rng_seed_track #(.NUM_SEEDS(NUM_SEEDS)) u_seeds (
    .clk(clk), .rst_n(rst_n), .seed_we(wr_seed), .seed_idx(seed_idx),
    .seed_val(wr_data), .seed_flat(seed_flat), .seeds_all(seeds_all)
  );

  // control and launch gating
  logic [31:0] ctrl_q;
  logic start_req, eng_busy, gen_done;

  assign start_req = wr_ctrl && seeds_all && wr_data[CTL_ENG] && wr_data[CTL_GO];

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_data & ~(32'h1 << CTL_GO);
  end

  rng_engine #(.NUM_SEEDS(NUM_SEEDS), .STEPS(STEPS)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .seed_flat(seed_flat),
    .busy(eng_busy), .done(gen_done), .out_flat(res_flat)
  );

  // status
  logic [2:0]  sw_q;
  logic [31:0] status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q <= '0;
    end else begin
      if (wr_stat) sw_q <= wr_data[ST_DONE:ST_SWLO];
      if (gen_done) sw_q[ST_DONE-ST_SWLO] <= 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[ST_READY]         = 1'b1;
    status[ST_SEEDS]         = seeds_all;
    status[ST_BUSY]          = eng_busy;
    status[ST_DONE:ST_SWLO]  = sw_q;
    status[ST_ERR]           = 1'b0;
  end

  // read port
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr == A_CTRL)      rd_mux = ctrl_q;
    else if (addr == A_STAT) rd_mux = status;
    else if (in_res)         rd_mux = res_flat[res_idx*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R2
  go_bit_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CTRL) |=> !rd_data[CTL_GO]);
  // R3
  stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !gen_done) |=> (status[ST_DONE:ST_SWLO] == $past(wr_data[ST_DONE:ST_SWLO])));
  // R5
  launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> ($past(seeds_all) && $past(wr_en) && $past(wr_data[CTL_ENG])));
  // R3
  const_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STAT) |=> (rd_data[ST_READY] && !rd_data[ST_ERR]));
endmodule

// File: tb/sim_seeded_rng_ctrl.sv
module sim_seeded_rng_ctrl;
  localparam int CLK_P = 10;
  localparam int NSTEP = 4;
  localparam int WD_LIMIT = 20000;

  logic clk = 0, rst_n = 0;
  logic [8:0] addr = '0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  always #(CLK_P/2) clk = ~clk;

  seeded_rng_ctrl u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic trk = 0, trk_d = 0;

  // monitor
  always @(posedge clk) trk_d <= rd_en && trk;
  always @(negedge clk) begin
    if (trk_d) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rd_data !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected < %0d", cyc, WD_LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [8:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; rd_en = 1; trk = 1;
    @(negedge clk);
    rd_en = 0; trk = 0;
  endtask

  task automatic peek(input logic [8:0] a, output logic [31:0] v);
    addr = a; rd_en = 1; trk = 0;
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  // independent model of the generator (R7, R8)
  function automatic logic [159:0] model(input logic [159:0] seed);
    logic [159:0] x, r;
    x = (seed == 160'd0) ? {5{32'h9E3779B9}} : seed;
    r = '0;
    for (int k = 0; k < 5; k++) begin
      for (int s = 0; s < NSTEP; s++) begin
        x = x ^ {x[152:0], 7'd0};
        x = x ^ {9'd0, x[159:9]};
        x = x ^ {x[146:0], 13'd0};
      end
      r[32*k +: 32] = x[31:0];
    end
    return r;
  endfunction

  task automatic load_seeds(input logic [159:0] s);
    for (int n = 0; n < 5; n++) wr(9'h140 + 9'(4*n), s[32*n +: 32]);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      peek(9'h010, v);
      if (v[5]) return;
    end
    n_cmp++; n_bad++;
    $display("FAIL R6: got no done flag expected status bit 5 set");
  endtask

  task automatic chk_results(input logic [159:0] exp, input string t);
    for (int k = 0; k < 5; k++) rd_chk(9'h160 + 9'(4*k), exp[32*k +: 32], t);
  endtask

  logic [159:0] seed_a, seed_b;

  initial begin
    seed_a = {32'h0BAD_F00D, 32'h1234_5678, 32'hDEAD_BEEF, 32'hCAFE_0001, 32'h0000_0042};
    seed_b = {32'h5555_AAAA, 32'h0F0F_F0F0, 32'h1357_9BDF, 32'h2468_ACE0, 32'h7777_0000};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    rd_chk(9'h000, 32'h0, "R1 ctrl");
    rd_chk(9'h010, 32'h1, "R1 status");
    chk_results(160'd0, "R1 results");

    // R5: no seeds loaded, launch refused; R2 go bit cleared
    wr(9'h000, 32'h18);
    rd_chk(9'h000, 32'h08, "R2 go cleared");
    repeat (30) @(negedge clk);
    rd_chk(9'h010, 32'h01, "R5 no seeds");
    rd_chk(9'h160, 32'h0, "R5 results untouched");

    // R4 seed marks
    for (int n = 0; n < 4; n++) wr(9'h140 + 9'(4*n), seed_a[32*n +: 32]);
    rd_chk(9'h010, 32'h01, "R4 four of five");
    wr(9'h150, seed_a[159:128]);
    rd_chk(9'h010, 32'h03, "R4 all five");

    // R10 undecoded space
    rd_chk(9'h140, 32'h0, "R10 seed reads zero");
    rd_chk(9'h1FC, 32'h0, "R10 top of window");
    rd_chk(9'h002, 32'h0, "R10 unaligned");
    wr(9'h1F0, 32'hFFFF_FFFF);
    wr(9'h004, 32'hFFFF_FFFF);
    rd_chk(9'h000, 32'h08, "R10 ctrl unchanged");
    rd_chk(9'h010, 32'h03, "R10 status unchanged");

    // R5 engine not selected
    wr(9'h000, 32'h10);
    repeat (30) @(negedge clk);
    rd_chk(9'h010, 32'h03, "R5 engine off");
    rd_chk(9'h000, 32'h00, "R2 readback");

    // R3 status write
    wr(9'h010, 32'hFFFF_FFFF);
    rd_chk(9'h010, 32'h3B, "R3 set flags");
    wr(9'h010, 32'h0);
    rd_chk(9'h010, 32'h03, "R3 clear flags");

    // R6 timing and R7 results
    wr(9'h000, 32'h18);
    rd_chk(9'h010, 32'h07, "R6 busy after launch");
    repeat (5*NSTEP - 2) @(negedge clk);
    rd_chk(9'h010, 32'h07, "R6 still busy last cycle");
    rd_chk(9'h010, 32'h23, "R6 done");
    chk_results(model(seed_a), "R7 results A");
    wr(9'h010, 32'h0);

    // R8 zero seed
    load_seeds(160'd0);
    wr(9'h000, 32'h18);
    wait_done();
    chk_results(model(160'd0), "R8 zero substitute");
    wr(9'h010, 32'h0);

    // R9 launch while busy
    load_seeds(seed_a);
    wr(9'h000, 32'h18);
    load_seeds(seed_b);
    wr(9'h000, 32'h18);
    wait_done();
    chk_results(model(seed_a), "R9 busy launch ignored");
    wr(9'h010, 32'h0);
    wr(9'h000, 32'h18);
    wait_done();
    chk_results(model(seed_b), "R7 results B");

    finish_run();
  end
endmodule